// File: doc/BRIEF.md
# Start-of-Packet Timestamp Router

This block stamps every received frame, regardless of its type, with the value of a free-running time counter taken in the cycle where the frame's first data block appears. The receive path flags the start of each frame per segment of its data bus. The block keeps a stamp only for those start cycles and routes it to one of six output lanes. Every other cycle yields no stamp. Each lane carries the stamp, a one-cycle valid strobe and a short-frame flag. The consumer uses the short-frame flag to discard stamps of frames too short to be trusted.

There are two routing modes. In per-port mode, lane k serves port k and follows that port's start flag. In wide segmented mode, one stream spreads over eight segments and can begin two frames in a single cycle. A start anywhere in segments 0 to 3 goes to lane 0, and a start in segments 4 to 7 goes to lane 2. Both can fire together. Each lane has an enable bit that decides whether its stamps are driven out. In wide mode, bit 0 of the enable gates both active lanes.

Top module: `sop_stamp_router`

## Requirements
- R1: While reset is held, and in the first cycle after it, every valid strobe and short flag is 0 and every stamp lane reads 0.
- R2: In per-port mode (mode_seg = 0), a start flag on seg_sop[k] with port_en[k] = 1 raises ts_vld[k] in the next cycle. Lane k then carries the ts_count value sampled in the start cycle.
- R3: In per-port mode, a start on port k while port_en[k] = 0 leaves lane k invalid, with its stamp at 0.
- R4: In wide mode (mode_seg = 1), a start in any of seg_sop[3:0] with port_en[0] = 1 raises ts_vld[0] one cycle later, carrying the stamp of the start cycle.
- R5: In wide mode, a start in any of seg_sop[7:4] with port_en[0] = 1 raises ts_vld[2] one cycle later. Starts in both halves in the same cycle raise both lanes together.
- R6: In wide mode, when several segments of one half flag a start, the lane reports only the lowest-numbered flagged segment of that half. Its short flag is seg_short of that segment.
- R7: In wide mode, lanes 1, 3, 4 and 5 stay invalid. Setting port_en[0] = 0 suppresses lanes 0 and 2.
- R8: A cycle with no start produces no valid strobe one cycle later. A lane that is not valid reads a stamp of 0 and a short flag of 0, so each strobe lasts one cycle per start.
- R9: ts_short[k] equals the seg_short bit of the reporting segment, and it is asserted only together with ts_vld[k].
- R10: In per-port mode, seg_sop[7:6] and seg_short[7:6] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_count | input | TS_W | Free-running time counter |
| seg_sop | input | NSEG | Per-segment start-of-frame flags |
| seg_short | input | NSEG | Per-segment short-frame marks |
| mode_seg | input | 1 | 0 = per-port routing, 1 = wide segmented routing |
| port_en | input | NPORT | Per-lane output enable |
| ts_out | output | NPORT*TS_W | Stamps, lane k at bits [k*TS_W +: TS_W] |
| ts_vld | output | NPORT | One-cycle valid strobe per lane |
| ts_short | output | NPORT | Short-frame flag per lane |

## Verification
The bench uses NPORT = 6 and NSEG = 8, and narrows TS_W to 16. Its counter starts just below the 16-bit wrap, so the rollover of the stamp is seen early in the run. The random phase alternates modes and enables, with dense start patterns, so halves carrying several starts and dual starts in one cycle come up often. Directed cycles cover lane disabling, priority inside a half, and the unused upper segments in per-port mode.

// File: rtl/sop_stamp_router.sv
module sop_stamp_router #(
  parameter int TS_W  = 32,
  parameter int NPORT = 6,
  parameter int NSEG  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TS_W-1:0]       ts_count,
  input  logic [NSEG-1:0]       seg_sop,
  input  logic [NSEG-1:0]       seg_short,
  input  logic                  mode_seg,
  input  logic [NPORT-1:0]      port_en,
  output logic [NPORT*TS_W-1:0] ts_out,
  output logic [NPORT-1:0]      ts_vld,
  output logic [NPORT-1:0]      ts_short
);
  localparam int HALF    = NSEG / 2;
  localparam int HI_LANE = 2;

  logic [NPORT-1:0] nxt_v, nxt_s;
  logic lo_hit, lo_sh, hi_hit, hi_sh;

  always_comb begin
    lo_hit = 1'b0;
    lo_sh  = 1'b0;
    hi_hit = 1'b0;
    hi_sh  = 1'b0;
    for (int i = HALF - 1; i >= 0; i--) begin
      if (seg_sop[i]) begin
        lo_hit = 1'b1;
        lo_sh  = seg_short[i];
      end
      if (seg_sop[i+HALF]) begin
        hi_hit = 1'b1;
        hi_sh  = seg_short[i+HALF];
      end
    end
  end

  always_comb begin
    nxt_v = '0;
    nxt_s = '0;
    if (mode_seg) begin
      nxt_v[0]       = lo_hit & port_en[0];
      nxt_s[0]       = lo_sh & lo_hit & port_en[0];
      nxt_v[HI_LANE] = hi_hit & port_en[0];
      nxt_s[HI_LANE] = hi_sh & hi_hit & port_en[0];
    end else begin
      for (int k = 0; k < NPORT; k++) begin
        nxt_v[k] = seg_sop[k] & port_en[k];
        nxt_s[k] = seg_short[k] & seg_sop[k] & port_en[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_vld   <= '0;
      ts_short <= '0;
      ts_out   <= '0;
    end else begin
      ts_vld   <= nxt_v;
      ts_short <= nxt_s;
      for (int k = 0; k < NPORT; k++)
        ts_out[k*TS_W +: TS_W] <= nxt_v[k] ? ts_count : '0;
    end
  end
endmodule

module sop_stamp_router_chk #(
  parameter int TS_W  = 32,
  parameter int NPORT = 6,
  parameter int NSEG  = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [TS_W-1:0]       ts_count,
  input logic [NSEG-1:0]       seg_sop,
  input logic [NSEG-1:0]       seg_short,
  input logic                  mode_seg,
  input logic [NPORT-1:0]      port_en,
  input logic [NPORT*TS_W-1:0] ts_out,
  input logic [NPORT-1:0]      ts_vld,
  input logic [NPORT-1:0]      ts_short
);
  localparam int HALF = NSEG / 2;
  localparam logic [NPORT-1:0] WIDE_LANES = NPORT'(5);

  // R2
  lane1_stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ts_vld[1] |-> ts_out[TS_W +: TS_W] == $past(ts_count));

  // R3
  lane1_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_seg && !port_en[1]) |=> !ts_vld[1]);

  // R5
  upper_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_seg && port_en[0] && |seg_sop[HALF +: HALF]) |=> ts_vld[2]);

  // R7
  wide_idle_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_seg |=> (ts_vld & ~WIDE_LANES) == '0);

  // R8
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_sop == '0) |=> (ts_vld == '0 && ts_out == '0));
endmodule

bind sop_stamp_router sop_stamp_router_chk #(.TS_W(TS_W), .NPORT(NPORT), .NSEG(NSEG)) chk (.*);

// File: tb/sop_stamp_router_test.sv
module sop_stamp_router_test;
  localparam int TS_W = 16, NPORT = 6, NSEG = 8;

  logic clk = 0, rst_n;
  logic [TS_W-1:0] cnt = 16'hFF00;
  logic [NSEG-1:0] sop, sh;
  logic mode;
  logic [NPORT-1:0] en;
  logic [NPORT*TS_W-1:0] ts_out;
  logic [NPORT-1:0] ts_vld, ts_short;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 1'b1;

  sop_stamp_router #(.TS_W(TS_W), .NPORT(NPORT), .NSEG(NSEG)) uut (
    .clk(clk), .rst_n(rst_n), .ts_count(cnt), .seg_sop(sop), .seg_short(sh),
    .mode_seg(mode), .port_en(en), .ts_out(ts_out), .ts_vld(ts_vld), .ts_short(ts_short));

  logic [NPORT-1:0] ev, es;
  logic [TS_W-1:0] ets;

  task automatic model();
    ev = '0; es = '0; ets = cnt;
    if (mode) begin
      for (int h = 0; h < 2; h++) begin
        bit found = 0;
        for (int i = 0; i < 4; i++)
          if (!found && sop[h*4+i]) begin
            found = 1;
            ev[h*2] = en[0];
            es[h*2] = en[0] & sh[h*4+i];
          end
      end
    end else
      for (int k = 0; k < NPORT; k++) begin
        ev[k] = sop[k] & en[k];
        es[k] = sop[k] & en[k] & sh[k];
      end
  endtask

  task automatic chk(string tag, string what, logic [TS_W-1:0] a, logic [TS_W-1:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, a, e);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "valid", TS_W'(ts_vld), TS_W'(ev));
    chk(tag, "short", TS_W'(ts_short), TS_W'(es));
    for (int k = 0; k < NPORT; k++)
      chk(tag, $sformatf("stamp lane %0d", k), ts_out[k*TS_W +: TS_W], ev[k] ? ets : '0);
  endtask

  task automatic cyc(string tag, logic [NSEG-1:0] s, logic [NSEG-1:0] f, logic m, logic [NPORT-1:0] e);
    sop = s; sh = f; mode = m; en = e;
    model();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; sop = '1; sh = '1; mode = 0; en = '1;
    repeat (3) @(negedge clk);
    ev = '0; es = '0; ets = '0;
    compare("R1");
    sop = '0; sh = '0;
    rst_n = 1;
    @(negedge clk);
    compare("R1");
    cyc("R2", 8'b0010_0101, 8'b0000_0100, 0, 6'h3F);
    cyc("R8", 8'h00, 8'hFF, 0, 6'h3F);
    cyc("R3", 8'b0011_1111, 8'h00, 0, 6'b10_1010);
    cyc("R9", 8'b0011_1111, 8'b0010_1001, 0, 6'h3F);
    cyc("R10", 8'b1100_0000, 8'hFF, 0, 6'h3F);
    cyc("R4", 8'b0000_1000, 8'h00, 1, 6'h01);
    cyc("R5", 8'b0100_0010, 8'h00, 1, 6'h01);
    cyc("R6", 8'b1010_0110, 8'b0101_0010, 1, 6'h01);
    cyc("R6", 8'b1100_1100, 8'b0100_1000, 1, 6'h01);
    cyc("R7", 8'hFF, 8'h00, 1, 6'h3E);
    cyc("R7", 8'hFF, 8'h00, 1, 6'h3F);
    cyc("R8", 8'h00, 8'h00, 1, 6'h3F);
    for (int n = 0; n < 4000; n++) begin
      logic m = (n / 50) % 2;
      logic [NSEG-1:0] s = 8'($urandom) & 8'($urandom);
      logic [NPORT-1:0] e = ($urandom % 4 == 0) ? 6'($urandom) : 6'h3F;
      cyc(m ? "R4" : "R2", s, 8'($urandom), m, e);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule